// File: doc/BRIEF.md
# Punctured Code Rate Search Controller

This controller works out which puncture rate a convolutionally coded stream was sent with. It drives a rate code to an inner decoder, which reports each decoded bit with a valid strobe and flags it with an error strobe when it is in error. Over a window of decoded bits the controller counts the flagged errors. It then compares the count with an 8-bit threshold that belongs to the rate under test. The first rate whose count is at or below its threshold is declared locked, and the search stops there.

In automatic mode the controller walks the enabled rates in ascending order and wraps around after the highest enabled one. A locked rate that later produces one bad window drops lock, and the search resumes at the next enabled rate. In manual mode the rate comes from a configuration field and is only judged, never stepped. A freeze control suspends everything. The window length is set by a 2-bit averaging code.

Top module: `rate_search_fsm`

## Requirements
- R1: After reset, `rate_sel` is 0 and `locked` is 0.
- R2: Rate codes are 0 = 1/2, 1 = 2/3, 2 = 3/4, 3 = 5/6 and 4 = the highest rate (7/8 or 6/7 by broadcast standard); `cfg_mask` bit i enables code i, and `rate_sel` never exceeds 4.
- R3: A measurement window spans 2^(AVG_BASE_LOG2 + 2*`cfg_avg`) cycles with `bit_valid` high; `bit_err` counts only when `bit_valid` is high, and the verdict is taken on the window's last valid bit.
- R4: The threshold for code i is `cfg_thresh[8i+7:8i]`; a window whose error count is at or below it sets `locked`, and a locked rate stays locked with its code unchanged while no failing window occurs.
- R5: In automatic mode, a window over threshold clears `locked` and moves to the next enabled code above the current one, wrapping from 4 to 0, and staying on the same code when it is the only one enabled.
- R6: In automatic mode with a nonzero mask, if the current code is not enabled, the next cycle moves to the next enabled code with `locked` cleared and a fresh window.
- R7: In automatic mode with an all-zero mask, `locked` is 0, the code holds and no window is counted.
- R8: In manual mode (`cfg_manual`=1) the code follows `cfg_force` one cycle later, values 5 to 7 act as 4, a load clears `locked`, and a failing window clears `locked` without changing the code.
- R9: While `cfg_freeze` is 1, the code, `locked` and the window progress all hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_manual | input | 1 | 0 automatic search, 1 manual rate |
| cfg_freeze | input | 1 | Hold rate, lock and window |
| cfg_avg | input | 2 | Averaging window code |
| cfg_mask | input | 5 | Enable bit per rate code |
| cfg_force | input | 3 | Rate code used in manual mode |
| cfg_thresh | input | 5*THR_W | Per-rate error thresholds, code i in byte i |
| bit_valid | input | 1 | One decoded bit this cycle |
| bit_err | input | 1 | That decoded bit is in error |
| rate_sel | output | 3 | Rate code driven to the decoder |
| locked | output | 1 | Current rate accepted |

## Verification
A vector table steps through error counts just under, at and over each rate's threshold. This separates the at-or-below acceptance rule from a strict comparison and shows the ascending walk, including the wrap from the top code. Mask patterns with gaps, a single enabled code and no enabled code show that the stepping and the jump away from a disabled code follow the mask. Manual loads, including out-of-range values, are checked against automatic stepping. Directed runs place errors on invalid cycles and use the longer window, to pin down exactly which bit closes a window, and they apply freeze both while locked and while searching.

// File: rtl/rate_search_fsm.sv
module rate_search_fsm #(
  parameter int AVG_BASE_LOG2 = 10,
  parameter int THR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_manual,
  input  logic               cfg_freeze,
  input  logic [1:0]         cfg_avg,
  input  logic [4:0]         cfg_mask,
  input  logic [2:0]         cfg_force,
  input  logic [5*THR_W-1:0] cfg_thresh,
  input  logic               bit_valid,
  input  logic               bit_err,
  output logic [2:0]         rate_sel,
  output logic               locked
);
  localparam int NRATES = 5;
  localparam int RW = 3;
  localparam int CW = AVG_BASE_LOG2 + 6;
  localparam int EW = THR_W + 1;
  localparam logic [RW-1:0] TOP = RW'(NRATES - 1);

  logic [RW-1:0]    rate_q, nxt, force_c;
  logic             lock_q;
  logic [CW-1:0]    bit_cnt, win_max;
  logic [EW-1:0]    err_cnt, err_tot;
  logic [THR_W-1:0] thr;
  logic [7:0]       mask_x;
  logic             last, pass;

  assign mask_x  = {3'b000, cfg_mask};
  assign win_max = CW'((64'd1 << (AVG_BASE_LOG2 + 2 * int'(cfg_avg))) - 64'd1);
  assign last    = bit_valid && (bit_cnt == win_max);
  assign err_tot = (&err_cnt) ? err_cnt : err_cnt + EW'(bit_valid & bit_err);
  assign thr     = cfg_thresh[int'(rate_q)*THR_W +: THR_W];
  assign pass    = err_tot <= EW'(thr);
  assign force_c = (cfg_force > TOP) ? TOP : cfg_force;

  always_comb begin
    nxt = rate_q;
    for (int i = NRATES; i >= 1; i--)
      if (mask_x[(int'(rate_q) + i) % NRATES])
        nxt = RW'((int'(rate_q) + i) % NRATES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= '0;
      lock_q  <= 1'b0;
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (cfg_freeze) begin
      rate_q <= rate_q;
    end else if (cfg_manual && rate_q != force_c) begin
      rate_q  <= force_c;
      lock_q  <= 1'b0;
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (!cfg_manual && cfg_mask == '0) begin
      lock_q  <= 1'b0;
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (!cfg_manual && !mask_x[rate_q]) begin
      rate_q  <= nxt;
      lock_q  <= 1'b0;
      bit_cnt <= '0;
      err_cnt <= '0;
    end else if (bit_valid) begin
      if (last) begin
        bit_cnt <= '0;
        err_cnt <= '0;
        lock_q  <= pass;
        if (!pass && !cfg_manual) rate_q <= nxt;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        err_cnt <= err_tot;
      end
    end
  end

  assign rate_sel = rate_q;
  assign locked   = lock_q;
endmodule

// File: rtl/rate_search_chk.sv
module rate_search_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_manual,
  input logic       cfg_freeze,
  input logic [4:0] cfg_mask,
  input logic [2:0] cfg_force,
  input logic       bit_valid,
  input logic [2:0] rate_sel,
  input logic       locked
);
  logic cur_en;
  assign cur_en = |(({3'b000, cfg_mask} >> rate_sel) & 8'd1);

  assert_rate_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel <= 3'd4);

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !bit_valid && !cfg_freeze && !cfg_manual && cur_en)
      |=> (locked && $stable(rate_sel)));

  assert_masked_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_freeze && !cfg_manual && cfg_mask != 5'd0 && !cur_en)
      |=> (!locked && rate_sel != $past(rate_sel)));

  assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_freeze && !cfg_manual && cfg_mask == 5'd0) |=> !locked);

  assert_manual_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_manual && !cfg_freeze)
      |=> (rate_sel == (($past(cfg_force) > 3'd4) ? 3'd4 : $past(cfg_force))));

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_freeze |=> ($stable(rate_sel) && $stable(locked)));
endmodule

bind rate_search_fsm rate_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_manual(cfg_manual), .cfg_freeze(cfg_freeze),
  .cfg_mask(cfg_mask), .cfg_force(cfg_force), .bit_valid(bit_valid),
  .rate_sel(rate_sel), .locked(locked)
);

// File: tb/sim_rate_search_fsm.sv
module sim_rate_search_fsm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_manual = 1'b0, cfg_freeze = 1'b0;
  logic [1:0]  cfg_avg = 2'd0;
  logic [4:0]  cfg_mask = 5'b11111;
  logic [2:0]  cfg_force = 3'd0;
  logic [39:0] cfg_thresh = {8'd4, 8'd3, 8'd2, 8'd1, 8'd0};
  logic        bit_valid = 1'b0, bit_err = 1'b0;
  logic [2:0]  rate_sel;
  logic        locked;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rate_search_fsm #(.AVG_BASE_LOG2(3), .THR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_manual(cfg_manual), .cfg_freeze(cfg_freeze),
    .cfg_avg(cfg_avg), .cfg_mask(cfg_mask), .cfg_force(cfg_force),
    .cfg_thresh(cfg_thresh), .bit_valid(bit_valid), .bit_err(bit_err),
    .rate_sel(rate_sel), .locked(locked)
  );

  // {manual, force, mask, errors in an 8-bit window, expected rate, expected lock}
  localparam logic [16:0] VEC [16] = '{
    {1'b0, 3'd0, 5'b11111, 4'd5, 3'd1, 1'b0},
    {1'b0, 3'd0, 5'b11111, 4'd1, 3'd1, 1'b1},
    {1'b0, 3'd0, 5'b11111, 4'd1, 3'd1, 1'b1},
    {1'b0, 3'd0, 5'b11111, 4'd2, 3'd2, 1'b0},
    {1'b0, 3'd0, 5'b11111, 4'd8, 3'd3, 1'b0},
    {1'b0, 3'd0, 5'b11111, 4'd8, 3'd4, 1'b0},
    {1'b0, 3'd0, 5'b11111, 4'd8, 3'd0, 1'b0},
    {1'b0, 3'd0, 5'b11111, 4'd0, 3'd0, 1'b1},
    {1'b0, 3'd0, 5'b10100, 4'd8, 3'd4, 1'b0},
    {1'b0, 3'd0, 5'b10100, 4'd8, 3'd2, 1'b0},
    {1'b0, 3'd0, 5'b10100, 4'd2, 3'd2, 1'b1},
    {1'b1, 3'd3, 5'b10100, 4'd8, 3'd3, 1'b0},
    {1'b1, 3'd3, 5'b10100, 4'd3, 3'd3, 1'b1},
    {1'b1, 3'd6, 5'b10100, 4'd4, 3'd4, 1'b1},
    {1'b0, 3'd0, 5'b00010, 4'd0, 3'd1, 1'b1},
    {1'b0, 3'd0, 5'b00010, 4'd5, 3'd1, 1'b0}
  };

  task automatic check(input string req, input logic [2:0] er, input logic el);
    n_run++;
    if (rate_sel !== er || locked !== el) begin
      n_fail++;
      $display("FAIL %s: rate=%0d lock=%0d expected rate=%0d lock=%0d",
               req, rate_sel, locked, er, el);
    end
  endtask

  task automatic send_bits(input int nbits, input int nerr);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_err = (i < nerr);
    end
    @(negedge clk);
    bit_valid = 1'b0;
    bit_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 3'd0, 1'b0);
    rst_n = 1'b1;

    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      cfg_manual = VEC[r][16];
      cfg_force  = VEC[r][15:13];
      cfg_mask   = VEC[r][12:8];
      @(negedge clk);
      send_bits(8, int'(VEC[r][7:4]));
      check($sformatf("R2/R4/R5/R6/R8 table row %0d", r), VEC[r][3:1], VEC[r][0]);
    end

    // R3: error strobes without valid are ignored
    cfg_mask = 5'b11111;
    @(negedge clk);
    bit_err = 1'b1;
    repeat (10) @(negedge clk);
    bit_err = 1'b0;
    send_bits(8, 0);
    check("R3 err without valid ignored", 3'd1, 1'b1);

    // R3: longer window closes on its 32nd valid bit
    cfg_avg = 2'd1;
    send_bits(31, 2);
    check("R3 window not yet closed", 3'd1, 1'b1);
    send_bits(1, 0);
    check("R3/R5 window closes and steps", 3'd2, 1'b0);
    cfg_avg = 2'd0;

    // R9: freeze while searching, even with current code masked
    cfg_freeze = 1'b1;
    cfg_mask = 5'b00001;
    send_bits(8, 8);
    check("R9 freeze while searching", 3'd2, 1'b0);
    cfg_mask = 5'b11111;
    cfg_freeze = 1'b0;
    send_bits(8, 0);
    check("R4 lock after unfreeze", 3'd2, 1'b1);

    // R9: freeze while locked
    cfg_freeze = 1'b1;
    send_bits(8, 8);
    check("R9 freeze while locked", 3'd2, 1'b1);
    cfg_freeze = 1'b0;

    // R7: all-zero mask
    cfg_mask = 5'b00000;
    @(negedge clk);
    check("R7 zero mask drops lock", 3'd2, 1'b0);
    send_bits(8, 0);
    check("R7 zero mask idle", 3'd2, 1'b0);
    cfg_mask = 5'b11111;
    @(negedge clk);
    send_bits(8, 2);
    check("R4 at threshold locks", 3'd2, 1'b1);

    // R1: reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset in operation", 3'd0, 1'b0);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule